// File: doc/BRIEF.md
# Single and Double Tap Detector

This block watches a stream of signed three-axis acceleration samples and reports short, sharp impacts as taps. A tap is counted when the magnitude on at least one enabled axis rises above a programmable threshold and falls back within a programmable number of time-base ticks. After a valid tap, a latency phase runs first. A window phase follows, and a second tap that starts inside the window turns the pair into a double tap. If no second tap arrives, the block reports a single tap when the window closes. An optional suppress mode cancels the double tap if the signal goes above threshold at any point between the two taps.

All timing is measured in ticks of an external single-cycle time base. The pulse-width limit uses one tick per count. Latency and window use `GAP_SCALE` ticks per count. Setting any timing register to zero turns off the function that depends on it. The block also keeps three source flags. They show which enabled axes were above threshold on the sample that started the reported tap, and they are rewritten at every event.

Top module: `tap_detect`

## Requirements
- R1: An axis is above threshold when its sample is valid, its enable bit is 1, and the absolute value of its two's complement sample is strictly greater than `cfg_thresh * 16`. Negative samples count by magnitude. Axes that are not enabled never count.
- R2: A tap whose above-threshold level lasts no more than `cfg_dur` ticks is valid. With double tap enabled and no second tap, it produces exactly one `single_tap` pulse.
- R3: A tap that stays above threshold for more than `cfg_dur` ticks produces no event.
- R4: When `cfg_dur` is zero, neither `single_tap` nor `double_tap` is ever issued.
- R5: After a valid first tap, latency lasts `2*cfg_latent` ticks and the window lasts `2*cfg_window` ticks. A second tap is accepted only if its rising edge falls inside the window, so after T ticks it is accepted when 2*latent <= T < 2*(latent+window). Without suppress, a rise during latency is ignored. A second tap of valid width gives one `double_tap` pulse. A second tap that is too long gives one `single_tap` pulse.
- R6: When the window closes with no second tap, one `single_tap` is issued and the block returns to idle. A later rise then starts a new first tap.
- R7: When `cfg_latent` or `cfg_window` is zero, double tap is off and each valid tap issues `single_tap` as soon as it ends.
- R8: With `cfg_suppress` set, any above-threshold level during latency or window (before a second tap starts) issues `single_tap` at once and drops the double tap.
- R9: `tap_src` is {X, Y, Z} in bits 2, 1, 0. At each event it takes the enabled axes that were above threshold on the sample that started the first tap. Between events it holds its value. A disabled axis reads 0 after the next event.
- R10: Tick counters saturate at their maximum value instead of wrapping. A level held for more than 1023 ticks is still rejected as too long.
- R11: After reset all outputs are 0. Each event is a one-cycle pulse, and `single_tap` and `double_tap` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Single-cycle time-base strobe |
| smp_valid | input | 1 | New sample strobe |
| smp_x | input | 16 | X sample, two's complement |
| smp_y | input | 16 | Y sample, two's complement |
| smp_z | input | 16 | Z sample, two's complement |
| cfg_thresh | input | 8 | Unsigned threshold, 16 sample LSBs per count |
| cfg_dur | input | 8 | Maximum tap width in ticks; 0 turns off detection |
| cfg_latent | input | 8 | Latency after the first tap, 2 ticks per count |
| cfg_window | input | 8 | Second-tap window, 2 ticks per count |
| cfg_axis_en | input | 3 | Axis enables {X, Y, Z} |
| cfg_suppress | input | 1 | Reject double tap if the level rises between taps |
| single_tap | output | 1 | Single-tap event pulse |
| double_tap | output | 1 | Double-tap event pulse |
| tap_src | output | 3 | Axes involved in the last event {X, Y, Z} |

## Verification
Stimulus sweeps the first tap's width to exactly the limit and one tick past it. It also sweeps the gap before a second tap across the last latency tick, the first and last window ticks, and the first tick after the window closes, which separates off-by-one faults in each phase counter. A between-tap bump is applied with and without suppress, which shows whether the rule is applied only when enabled. Threshold probes at the limit and one LSB above it, with positive and negative signs, check the strict magnitude compare. Taps on changing axis sets with changing enables check how the source flags are overwritten and held. A very long pulse checks that the counters saturate rather than wrap.

// File: rtl/tap_pkg.sv
package tap_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HIT1,
        ST_LAT,
        ST_WIN,
        ST_HIT2
    } tap_st_e;
endpackage

// File: rtl/tap_axis_cmp.sv
module tap_axis_cmp #(
    parameter int SMP_W     = 16,
    parameter int THR_SHIFT = 4
) (
    input  logic signed [SMP_W-1:0] smp,
    input  logic [7:0]              thr,
    output logic                    hit
);
    localparam int LIM_W = 8 + THR_SHIFT;

    logic [SMP_W-1:0] mag;
    logic [LIM_W-1:0] lim;

    always_comb begin
        // magnitude of a two's complement value; the most negative code maps to 2^(W-1)
        mag = smp[SMP_W-1] ? SMP_W'(-smp) : SMP_W'(smp);
        lim = LIM_W'(thr) << THR_SHIFT;
        hit = (mag > SMP_W'(lim));
    end
endmodule

// File: rtl/tap_level_stage.sv
module tap_level_stage #(
    parameter int NAX = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           valid,
    input  logic [NAX-1:0] hit,
    input  logic [NAX-1:0] axis_en,
    output logic [NAX-1:0] lvl,
    output logic           rise
);
    typedef struct packed {
        logic [NAX-1:0] lvl;
        logic           prev;
    } lvl_t;

    lvl_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.prev = |r_q.lvl;
        if (valid) r_d.lvl = hit & axis_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign lvl  = r_q.lvl;
    assign rise = (|r_q.lvl) & ~r_q.prev;

    // R2: a start of level is reported for exactly one cycle
    p_rise_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/tap_seq_fsm.sv
module tap_seq_fsm
    import tap_pkg::*;
#(
    parameter int NAX       = 3,
    parameter int GAP_SCALE = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [NAX-1:0] lvl,
    input  logic           rise,
    input  logic [7:0]     cfg_dur,
    input  logic [7:0]     cfg_latent,
    input  logic [7:0]     cfg_window,
    input  logic           cfg_suppress,
    output logic           single_q,
    output logic           double_q,
    output logic [NAX-1:0] src_q
);
    localparam int CW = 8 + $clog2(GAP_SCALE) + 1;
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    typedef struct packed {
        tap_st_e        st;
        logic [CW-1:0]  cnt;
        logic [NAX-1:0] cap;
        logic [NAX-1:0] src;
        logic           sgl;
        logic           dbl;
    } fsm_t;

    fsm_t r_d, r_q;

    logic          any;
    logic          dbl_en;
    logic [CW-1:0] dur_lim, lat_lim, win_lim, cnt_inc;

    always_comb begin
        any     = |lvl;
        dbl_en  = (cfg_latent != 8'd0) && (cfg_window != 8'd0);
        dur_lim = CW'(cfg_dur);
        lat_lim = CW'(cfg_latent) * CW'(GAP_SCALE);
        win_lim = CW'(cfg_window) * CW'(GAP_SCALE);
        cnt_inc = (r_q.cnt == CNT_MAX) ? r_q.cnt : r_q.cnt + 1'b1;

        r_d     = r_q;
        r_d.sgl = 1'b0;
        r_d.dbl = 1'b0;

        if (cfg_dur == 8'd0) begin
            r_d.st  = ST_IDLE;
            r_d.cnt = '0;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (rise) begin
                        r_d.st  = ST_HIT1;
                        r_d.cnt = '0;
                        r_d.cap = lvl;
                    end
                end
                ST_HIT1: begin
                    if (!any) begin
                        r_d.cnt = '0;
                        if (r_q.cnt > dur_lim) begin
                            r_d.st = ST_IDLE;
                        end else if (dbl_en) begin
                            r_d.st = ST_LAT;
                        end else begin
                            r_d.st  = ST_IDLE;
                            r_d.sgl = 1'b1;
                            r_d.src = r_q.cap;
                        end
                    end else if (tick) begin
                        r_d.cnt = cnt_inc;
                    end
                end
                ST_LAT: begin
                    if (cfg_suppress && any) begin
                        r_d.st  = ST_IDLE;
                        r_d.sgl = 1'b1;
                        r_d.src = r_q.cap;
                    end else if (tick) begin
                        if (cnt_inc >= lat_lim) begin
                            r_d.st  = ST_WIN;
                            r_d.cnt = '0;
                        end else begin
                            r_d.cnt = cnt_inc;
                        end
                    end
                end
                ST_WIN: begin
                    if (rise) begin
                        r_d.st  = ST_HIT2;
                        r_d.cnt = '0;
                    end else if (cfg_suppress && any) begin
                        r_d.st  = ST_IDLE;
                        r_d.sgl = 1'b1;
                        r_d.src = r_q.cap;
                    end else if (tick) begin
                        if (cnt_inc >= win_lim) begin
                            r_d.st  = ST_IDLE;
                            r_d.sgl = 1'b1;
                            r_d.src = r_q.cap;
                        end else begin
                            r_d.cnt = cnt_inc;
                        end
                    end
                end
                ST_HIT2: begin
                    if (!any) begin
                        r_d.st  = ST_IDLE;
                        r_d.cnt = '0;
                        r_d.src = r_q.cap;
                        if (r_q.cnt > dur_lim) r_d.sgl = 1'b1;
                        else                   r_d.dbl = 1'b1;
                    end else if (tick) begin
                        r_d.cnt = cnt_inc;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign single_q = r_q.sgl;
    assign double_q = r_q.dbl;
    assign src_q    = r_q.src;

    // R11: the two event outputs are exclusive and each lasts one cycle
    p_no_both_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(single_q && double_q));
    p_sgl_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        single_q |=> !single_q);
    // R9: source flags move only together with an event
    p_src_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(src_q) |-> (single_q || double_q));
    // R4: a zero width limit keeps both events quiet
    p_dur_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dur == 8'd0) |=> !(single_q || double_q));
    // R10: a held level keeps the width counter pinned at its ceiling
    p_cnt_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HIT1 && r_q.cnt == CNT_MAX && any && cfg_dur != 8'd0)
        |=> (r_q.cnt == CNT_MAX));
endmodule

// File: rtl/tap_detect.sv
module tap_detect #(
    parameter int SMP_W     = 16,
    parameter int THR_SHIFT = 4,
    parameter int GAP_SCALE = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_x,
    input  logic signed [SMP_W-1:0] smp_y,
    input  logic signed [SMP_W-1:0] smp_z,
    input  logic [7:0]              cfg_thresh,
    input  logic [7:0]              cfg_dur,
    input  logic [7:0]              cfg_latent,
    input  logic [7:0]              cfg_window,
    input  logic [2:0]              cfg_axis_en,
    input  logic                    cfg_suppress,
    output logic                    single_tap,
    output logic                    double_tap,
    output logic [2:0]              tap_src
);
    localparam int NAX = 3;

    logic [NAX-1:0][SMP_W-1:0] smp_all;
    logic [NAX-1:0]            hit;
    logic [NAX-1:0]            lvl;
    logic                      rise;

    assign smp_all = {smp_x, smp_y, smp_z};

    for (genvar a = 0; a < NAX; a++) begin : g_axis
        tap_axis_cmp #(
            .SMP_W     (SMP_W),
            .THR_SHIFT (THR_SHIFT)
        ) u_cmp (
            .smp (signed'(smp_all[a])),
            .thr (cfg_thresh),
            .hit (hit[a])
        );
    end

    tap_level_stage #(.NAX(NAX)) u_lvl (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (smp_valid),
        .hit     (hit),
        .axis_en (cfg_axis_en),
        .lvl     (lvl),
        .rise    (rise)
    );

    tap_seq_fsm #(
        .NAX       (NAX),
        .GAP_SCALE (GAP_SCALE)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .lvl          (lvl),
        .rise         (rise),
        .cfg_dur      (cfg_dur),
        .cfg_latent   (cfg_latent),
        .cfg_window   (cfg_window),
        .cfg_suppress (cfg_suppress),
        .single_q     (single_tap),
        .double_q     (double_tap),
        .src_q        (tap_src)
    );
endmodule

// File: tb/tap_detect_tb_top.sv
module tap_detect_tb_top;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n;
    logic              tick;
    logic              smp_valid;
    logic signed [15:0] smp_x, smp_y, smp_z;
    logic [7:0]        cfg_thresh, cfg_dur, cfg_latent, cfg_window;
    logic [2:0]        cfg_axis_en;
    logic              cfg_suppress;
    logic              single_tap, double_tap;
    logic [2:0]        tap_src;

    tap_detect dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .smp_valid(smp_valid),
        .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
        .cfg_thresh(cfg_thresh), .cfg_dur(cfg_dur), .cfg_latent(cfg_latent),
        .cfg_window(cfg_window), .cfg_axis_en(cfg_axis_en),
        .cfg_suppress(cfg_suppress), .single_tap(single_tap),
        .double_tap(double_tap), .tap_src(tap_src)
    );

    int n_chk = 0;
    int n_fail = 0;
    int s_cnt = 0;
    int d_cnt = 0;
    int both_cnt = 0;

    always @(posedge clk) begin
        if (single_tap) s_cnt++;
        if (double_tap) d_cnt++;
        if (single_tap && double_tap) both_cnt++;
    end

    // dur, latent, window, suppress, bump, width1, gap, width2, exp single, exp double
    typedef struct packed {
        logic [7:0] dur;
        logic [7:0] lat;
        logic [7:0] win;
        logic       sup;
        logic       bump;
        logic [7:0] w1;
        logic [7:0] gap;
        logic [7:0] w2;
        logic [1:0] es;
        logic [1:0] ed;
    } row_t;

    localparam int NROWS = 13;
    localparam row_t ROWS [NROWS] = '{
        '{8'd5, 8'd2, 8'd3, 1'b0, 1'b0, 8'd3, 8'd0,  8'd0, 2'd1, 2'd0},
        '{8'd5, 8'd2, 8'd3, 1'b0, 1'b0, 8'd5, 8'd0,  8'd0, 2'd1, 2'd0},
        '{8'd5, 8'd2, 8'd3, 1'b0, 1'b0, 8'd6, 8'd0,  8'd0, 2'd0, 2'd0},
        '{8'd5, 8'd2, 8'd3, 1'b0, 1'b0, 8'd2, 8'd5,  8'd2, 2'd0, 2'd1},
        '{8'd5, 8'd2, 8'd3, 1'b0, 1'b0, 8'd2, 8'd3,  8'd2, 2'd1, 2'd0},
        '{8'd5, 8'd2, 8'd3, 1'b0, 1'b0, 8'd2, 8'd9,  8'd2, 2'd0, 2'd1},
        '{8'd5, 8'd2, 8'd3, 1'b0, 1'b0, 8'd2, 8'd10, 8'd2, 2'd2, 2'd0},
        '{8'd5, 8'd2, 8'd3, 1'b0, 1'b0, 8'd2, 8'd5,  8'd6, 2'd1, 2'd0},
        '{8'd5, 8'd0, 8'd3, 1'b0, 1'b0, 8'd2, 8'd5,  8'd2, 2'd2, 2'd0},
        '{8'd5, 8'd2, 8'd0, 1'b0, 1'b0, 8'd2, 8'd5,  8'd2, 2'd2, 2'd0},
        '{8'd5, 8'd2, 8'd3, 1'b0, 1'b1, 8'd2, 8'd5,  8'd2, 2'd0, 2'd1},
        '{8'd5, 8'd2, 8'd3, 1'b1, 1'b1, 8'd2, 8'd5,  8'd2, 2'd2, 2'd0},
        '{8'd0, 8'd2, 8'd3, 1'b0, 1'b0, 8'd2, 8'd5,  8'd2, 2'd0, 2'd0}
    };

    function automatic string row_tag(input int i);
        case (i)
            0, 1:          return "R2";
            2:             return "R3";
            3, 4, 5, 7, 10: return "R5";
            6:             return "R6";
            8, 9:          return "R7";
            11:            return "R8";
            default:       return "R4";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            idle(2);
        end
    endtask

    task automatic put(input logic signed [15:0] x, input logic signed [15:0] y,
                       input logic signed [15:0] z);
        @(negedge clk);
        smp_valid = 1'b1; smp_x = x; smp_y = y; smp_z = z;
        @(negedge clk);
        smp_valid = 1'b0;
        idle(3);
    endtask

    task automatic tap(input logic signed [15:0] x, input logic signed [15:0] y,
                       input logic signed [15:0] z, input int w);
        put(x, y, z);
        ticks(w);
        put(16'sd0, 16'sd0, 16'sd0);
    endtask

    task automatic expect_events(input int s0, input int d0, input int es, input int ed,
                                 input string tag);
        chk((s_cnt - s0) == es, {tag, " single count"}, s_cnt - s0, es);
        chk((d_cnt - d0) == ed, {tag, " double count"}, d_cnt - d0, ed);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int s0, d0;
        rst_n = 1'b0; tick = 1'b0; smp_valid = 1'b0;
        smp_x = '0; smp_y = '0; smp_z = '0;
        cfg_thresh = 8'h10; cfg_dur = 8'd5; cfg_latent = 8'd2; cfg_window = 8'd3;
        cfg_axis_en = 3'b111; cfg_suppress = 1'b0;
        idle(5);
        rst_n = 1'b1;
        idle(2);
        // R11: quiet outputs after reset
        chk(!single_tap && !double_tap, "R11 events after reset",
            int'({single_tap, double_tap}), 0);
        chk(tap_src == 3'b000, "R11 source after reset", tap_src, 0);

        // table walk over widths, gaps, disables and suppress
        for (int i = 0; i < NROWS; i++) begin
            cfg_dur = ROWS[i].dur; cfg_latent = ROWS[i].lat;
            cfg_window = ROWS[i].win; cfg_suppress = ROWS[i].sup;
            idle(2);
            s0 = s_cnt; d0 = d_cnt;
            tap(16'sd400, 16'sd0, 16'sd0, int'(ROWS[i].w1));
            if (ROWS[i].bump) put(16'sd400, 16'sd0, 16'sd0);
            if (ROWS[i].bump) put(16'sd0, 16'sd0, 16'sd0);
            ticks(int'(ROWS[i].gap));
            if (ROWS[i].w2 != 8'd0) tap(16'sd400, 16'sd0, 16'sd0, int'(ROWS[i].w2));
            ticks(30);
            expect_events(s0, d0, int'(ROWS[i].es), int'(ROWS[i].ed), row_tag(i));
        end

        // R1: strict magnitude compare against thresh*16 = 256, both signs, enables
        cfg_dur = 8'd5; cfg_latent = 8'd0; cfg_window = 8'd3; cfg_suppress = 1'b0;
        s0 = s_cnt; d0 = d_cnt;
        tap(16'sd256, 16'sd0, 16'sd0, 1); idle(4);
        expect_events(s0, d0, 0, 0, "R1 at limit");
        s0 = s_cnt;
        tap(16'sd257, 16'sd0, 16'sd0, 1); idle(4);
        expect_events(s0, d0, 1, 0, "R1 one above");
        s0 = s_cnt;
        tap(-16'sd257, 16'sd0, 16'sd0, 1); idle(4);
        expect_events(s0, d0, 1, 0, "R1 negative");
        cfg_axis_en = 3'b011;
        s0 = s_cnt;
        tap(16'sd400, 16'sd0, 16'sd0, 1); idle(4);
        expect_events(s0, d0, 0, 0, "R1 disabled axis");

        // R9: source flags {X,Y,Z}
        cfg_axis_en = 3'b111;
        tap(16'sd300, 16'sd0, -16'sd300, 1); idle(4);
        chk(tap_src == 3'b101, "R9 x and z", tap_src, 5);
        cfg_axis_en = 3'b011;
        tap(16'sd300, 16'sd0, -16'sd300, 1); idle(4);
        chk(tap_src == 3'b001, "R9 disabled x cleared", tap_src, 1);
        cfg_axis_en = 3'b111;
        tap(16'sd0, 16'sd300, 16'sd0, 1); idle(4);
        chk(tap_src == 3'b010, "R9 overwrite y", tap_src, 2);
        tap(16'sd0, 16'sd100, 16'sd0, 1); idle(4);
        chk(tap_src == 3'b010, "R9 held without event", tap_src, 2);

        // R10: very long level is rejected even past the counter ceiling
        cfg_dur = 8'd255;
        s0 = s_cnt; d0 = d_cnt;
        tap(16'sd400, 16'sd0, 16'sd0, 1100); idle(4);
        expect_events(s0, d0, 0, 0, "R10 saturated width");
        chk(tap_src == 3'b010, "R10 source untouched", tap_src, 2);

        // R11: never both events together
        chk(both_cnt == 0, "R11 exclusive events", both_cnt, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule